// File: doc/BRIEF.md
# Clock-Fail Interrupt Watchdog

This block decides what happens when the reference oscillator is lost. It runs on a backup system clock that keeps going during the failure. An asynchronous clock-fail indication is synchronized into that domain. Two reaction policies are available. In the default policy, chosen at power-up, a failure drives a missing-clock reset request at once. Once software selects the interrupt policy, a failure instead latches a sticky clock-fail flag and an interrupt flag, and it sends a one-cycle non-maskable interrupt pulse to the CPU. It also starts a 16-bit grace counter. If software has not cleared the clock-fail flag by the time the counter reaches the programmed period, the block raises an internal reset. That reset feeds the missing-clock reset request and nothing else.

Software reaches the block through a small register port. A write takes one cycle, and a read is combinational on the address. Through this port software can read the flags, clear them, force a failure for test, select the policy, set the period and read the running count. The latched clock-fail state is also driven out as a trip signal, so that PWM outputs can be forced to high impedance. All pins are plain control and status signals. There is no streaming data and therefore no back-pressure.

Top module: `clkfail_nmi_wd`

## Requirements
- R1: After reset the policy bit (address 3, bit 0) is 0. In this state a clock-fail input drives `mclk_rst_req_o` high on the second rising edge after it rises, gives no interrupt pulse and leaves the count at 0.
- R2: The clock-fail input passes through a two-stage synchronizer. In the interrupt policy the clock-fail flag is set on the third rising edge after the input rises.
- R3: In the interrupt policy, setting the clock-fail flag (address 0, bit 1) also sets the interrupt flag (address 0, bit 0). `nmi_irq_o` is then high for exactly one cycle, the cycle after that edge.
- R4: While the clock-fail flag is set in the interrupt policy, the count (address 5) goes up by one each cycle from 0. At any other time it returns to 0. Writes to address 5 have no effect.
- R5: In the cycle after the count is greater than or equal to the period (address 4), `nmi_rst_o` goes high and stays high until reset. `mclk_rst_req_o` is high whenever `nmi_rst_o` is high.
- R6: Writing 1 to bit 1 of address 1 clears the clock-fail flag, and writing 1 to bit 0 clears the interrupt flag. Each bit acts alone. Clearing the clock-fail flag before the period is reached returns the count to 0 and no reset follows. A set in the same cycle takes priority over a clear.
- R7: Writing 1 to bit 1 of address 2 sets the clock-fail flag just as a synchronized failure does.
- R8: When `rst_n` is low, both flags, the count, the policy bit and `nmi_rst_o` are cleared, and the period returns to 16'h7FFF.
- R9: `trip_o` is high exactly while the clock-fail flag is set.
- R10: A new period value is used by the comparison in the cycle right after the write. If the running count already meets or exceeds the new value, the reset fires one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backup system clock |
| rst_n | input | 1 | Active-low system reset (pin or resulting internal reset) |
| fail_async_i | input | 1 | Asynchronous clock-loss indication |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on address |
| nmi_irq_o | output | 1 | One-cycle non-maskable interrupt pulse |
| nmi_rst_o | output | 1 | Internal reset after the grace period expires |
| mclk_rst_req_o | output | 1 | Missing-clock reset request to system reset logic |
| trip_o | output | 1 | Clock-fail trip for PWM protection |

## Verification
Several rules are checked by the assertions on every cycle. The interrupt pulse is never longer than one cycle. The interrupt flag rises together with the clock-fail flag under the interrupt policy. The count falls back to zero whenever counting is disabled. The internal reset is only ever raised because the count has met the period. The immediate reset request in the default policy is also checked continuously. The bench scenarios cover what needs a sequence of events: the exact synchronizer latency, the cycle on which the period expires, a rescue by clearing the flags in time, a forced failure, a period shortened while counting, writes to the read-only count, and reset values.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int INT_BIT = 0;
  localparam int CF_BIT  = 1;
  localparam int SEL_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG = 3'd0,
    A_CLR  = 3'd1,
    A_FRC  = 3'd2,
    A_CFG  = 3'd3,
    A_PRD  = 3'd4,
    A_CNT  = 3'd5
  } cf_addr_e;
endpackage

// File: rtl/clkfail_sync.sv
module clkfail_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/clkfail_flags.sv
module clkfail_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_sel,
  input  logic fail_sync,
  input  logic frc_cf,
  input  logic clr_cf,
  input  logic clr_int,
  output logic cf_flag,
  output logic int_flag,
  output logic irq_pulse
);
  logic cf_set;
  logic int_set;
  logic int_prev;

  // a fresh failure event (hardware or forced) arms the interrupt only in the deferred policy
  assign cf_set  = fail_sync | frc_cf;
  assign int_set = cf_set & ~cf_flag & nmi_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_flag  <= 1'b0;
      int_flag <= 1'b0;
      int_prev <= 1'b0;
    end else begin
      if (cf_set)      cf_flag <= 1'b1;
      else if (clr_cf) cf_flag <= 1'b0;
      if (int_set)      int_flag <= 1'b1;
      else if (clr_int) int_flag <= 1'b0;
      int_prev <= int_flag;
    end
  end

  assign irq_pulse = int_flag & ~int_prev;
endmodule

// File: rtl/clkfail_wdcnt.sv
module clkfail_wdcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         expired
);
  logic reached;

  assign reached = run && (count >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
    end else begin
      if (!run)          count <= '0;
      else if (!reached) count <= count + 1'b1;
      if (reached) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/clkfail_nmi_wd.sv
module clkfail_nmi_wd
  import clkfail_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          SYNC_LEN  = 2,
  parameter logic [15:0] PRD_RESET = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_async_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              nmi_irq_o,
  output logic              nmi_rst_o,
  output logic              mclk_rst_req_o,
  output logic              trip_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             fail_sync;
  logic             cf_flag;
  logic             int_flag;
  logic             nmi_sel_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_clr, wr_frc, wr_cfg, wr_prd;

  assign wr_clr = reg_wr_i && (reg_addr_i == A_CLR);
  assign wr_frc = reg_wr_i && (reg_addr_i == A_FRC);
  assign wr_cfg = reg_wr_i && (reg_addr_i == A_CFG);
  assign wr_prd = reg_wr_i && (reg_addr_i == A_PRD);

  clkfail_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(fail_async_i),
    .q_sync (fail_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_sel_q <= 1'b0;
      period_q  <= PRD_RESET[CNT_W-1:0];
    end else begin
      if (wr_cfg) nmi_sel_q <= reg_wdata_i[SEL_BIT];
      if (wr_prd) period_q  <= reg_wdata_i[CNT_W-1:0];
    end
  end

  clkfail_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_sel  (nmi_sel_q),
    .fail_sync(fail_sync),
    .frc_cf   (wr_frc && reg_wdata_i[CF_BIT]),
    .clr_cf   (wr_clr && reg_wdata_i[CF_BIT]),
    .clr_int  (wr_clr && reg_wdata_i[INT_BIT]),
    .cf_flag  (cf_flag),
    .int_flag (int_flag),
    .irq_pulse(nmi_irq_o)
  );

  clkfail_wdcnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cf_flag && nmi_sel_q),
    .period (period_q),
    .count  (cnt_q),
    .expired(nmi_rst_o)
  );

  // immediate policy bypasses the grace window; the internal reset only joins this request
  assign mclk_rst_req_o = (fail_sync && !nmi_sel_q) || nmi_rst_o;
  assign trip_o         = cf_flag;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_FLAG: begin
        reg_rdata_o[CF_BIT]  = cf_flag;
        reg_rdata_o[INT_BIT] = int_flag;
      end
      A_CFG:   reg_rdata_o[SEL_BIT] = nmi_sel_q;
      A_PRD:   reg_rdata_o = {{PAD_W{1'b0}}, period_q};
      A_CNT:   reg_rdata_o = {{PAD_W{1'b0}}, cnt_q};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/clkfail_nmi_wd_chk.sv
module clkfail_nmi_wd_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fail_sync,
  input logic             nmi_sel_q,
  input logic             cf_flag,
  input logic             int_flag,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period_q,
  input logic             nmi_irq_o,
  input logic             nmi_rst_o,
  input logic             mclk_rst_req_o
);
  // R1
  a_r1_immediate_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_sync && !nmi_sel_q) |-> mclk_rst_req_o);
  // R3
  a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_irq_o |=> !nmi_irq_o);
  // R3
  a_r3_int_with_cf: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cf_flag) && $past(nmi_sel_q)) |-> int_flag);
  // R4
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(cf_flag && nmi_sel_q) |=> (cnt_q == '0));
  // R5
  a_r5_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_rst_o) |-> $past(cf_flag && nmi_sel_q && (cnt_q >= period_q)));
  // R5
  a_r5_feeds_req: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rst_o |-> mclk_rst_req_o);
endmodule

bind clkfail_nmi_wd clkfail_nmi_wd_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/clkfail_nmi_wd_test.sv
module clkfail_nmi_wd_test;
  import clkfail_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fail_async_i = 1'b0;
  logic              reg_wr_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;
  logic              nmi_irq_o, nmi_rst_o, mclk_rst_req_o, trip_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  clkfail_nmi_wd uut (
    .clk(clk), .rst_n(rst_n), .fail_async_i(fail_async_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .nmi_irq_o(nmi_irq_o), .nmi_rst_o(nmi_rst_o),
    .mclk_rst_req_o(mclk_rst_req_o), .trip_o(trip_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fail_async_i = 1'b0; reg_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_values();
    logic [15:0] d;
    do_reset();
    rd(A_FLAG, d); check("R8 flags", d, 0);
    rd(A_CFG, d);  check("R8 cfg", d, 0);
    rd(A_PRD, d);  check("R8 period", d, 16'h7FFF);
    rd(A_CNT, d);  check("R8 count", d, 0);
    check("R8 nmi_rst", nmi_rst_o, 0);
    check("R9 trip idle", trip_o, 0);
  endtask

  task automatic t_immediate();
    logic [15:0] d;
    int irqs = 0;
    do_reset();
    fail_async_i = 1'b1;
    @(negedge clk);
    check("R1 req not after one edge", mclk_rst_req_o, 0);
    @(negedge clk);
    check("R1 req after two edges", mclk_rst_req_o, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (nmi_irq_o) irqs++;
    end
    check("R1 no irq", irqs, 0);
    rd(A_CNT, d); check("R1 no counting", d, 0);
    check("R1 no nmi_rst", nmi_rst_o, 0);
  endtask

  task automatic t_nmi_expire();
    logic [15:0] d;
    int seen = 0;
    do_reset();
    wr(A_CFG, 16'h0001);
    wr(A_PRD, 16'd10);
    fail_async_i = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (trip_o && seen == 0) begin
        seen = i;
        check("R3 irq pulse", nmi_irq_o, 1);
        break;
      end
    end
    check("R2 flag on third edge", seen, 3);
    check("R9 trip set", trip_o, 1);
    rd(A_FLAG, d); check("R3 both flags", d, 3);
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      rd(A_CNT, d);
      if (k == 1) check("R3 irq single cycle", nmi_irq_o, 0);
      if (k <= 10) begin
        check("R4 count step", d, k);
        check("R5 no early reset", nmi_rst_o, 0);
      end else begin
        check("R5 reset after period", nmi_rst_o, 1);
        check("R5 feeds mclk req", mclk_rst_req_o, 1);
        check("R4 count holds", d, 10);
      end
    end
    repeat (3) @(negedge clk);
    check("R5 reset held", nmi_rst_o, 1);
    do_reset();
    rd(A_FLAG, d); check("R8 flags cleared by reset", d, 0);
    check("R8 nmi_rst cleared", nmi_rst_o, 0);
  endtask

  task automatic t_rescue();
    logic [15:0] d;
    int rsts = 0;
    do_reset();
    wr(A_CFG, 16'h0001);
    wr(A_PRD, 16'd10);
    fail_async_i = 1'b1;
    for (int i = 0; i < 8 && !trip_o; i++) @(negedge clk);
    fail_async_i = 1'b0;
    repeat (2) @(negedge clk);
    wr(A_CLR, 16'h0003);
    @(negedge clk);
    rd(A_FLAG, d); check("R6 flags cleared", d, 0);
    rd(A_CNT, d);  check("R6 count back to zero", d, 0);
    check("R9 trip cleared", trip_o, 0);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (nmi_rst_o) rsts++;
    end
    check("R6 reset prevented", rsts, 0);
  endtask

  task automatic t_force_and_period();
    logic [15:0] d;
    do_reset();
    wr(A_CFG, 16'h0001);
    wr(A_PRD, 16'd20);
    wr(A_FRC, 16'h0002);
    check("R7 force sets flag", trip_o, 1);
    rd(A_FLAG, d); check("R7 force sets both flags", d, 3);
    wr(A_CLR, 16'h0001);
    rd(A_FLAG, d); check("R6 int-only clear", d, 2);
    wr(A_CNT, 16'h1234);
    rd(A_CNT, d);  check("R4 count not writable", (d != 16'h1234 && d < 16'd20), 1);
    wr(A_PRD, 16'd3);
    check("R10 old period still compared", nmi_rst_o, 0);
    @(negedge clk);
    check("R10 new period takes effect", nmi_rst_o, 1);
  endtask

  task automatic t_cnt_write_idle();
    logic [15:0] d;
    do_reset();
    wr(A_CNT, 16'h00AA);
    rd(A_CNT, d); check("R4 write ignored while idle", d, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_values();
    t_immediate();
    t_nmi_expire();
    t_rescue();
    t_force_and_period();
    t_cnt_write_idle();
    finish_run();
  end
endmodule